// File: doc/BRIEF.md
# Flagged Mailbox Port Array

This block holds 129 single-word mailboxes, indexed 0 to 128. Each mailbox is a 32-bit data register with a one-bit occupancy flag (1 = full, 0 = empty). A processing core and a set of peripherals share the array and use it to pass words in either direction. Routines running on the core can also use it to pass words among themselves.

Each side has its own request port. A request carries an operation code, a mailbox index and write data. The result appears on the same side one cycle later as a success bit and read data. Plain reads and writes ignore the flag. Separate operations set or clear the flag. Two conditional operations give a handshaked transfer:
- A conditional write succeeds only into an empty mailbox.
- A conditional read succeeds only from a full mailbox.

All flags are exported as one vector so that a routine dispatcher can start work when mailboxes fill or drain.

Top module: `flagged_mailbox`

## Requirements
- R1: While rst_n is low at a rising edge, every flag becomes empty, every data word becomes zero, and both success outputs and both read-data outputs become zero.
- R2: Operation codes are 0 idle, 1 plain read, 2 plain write, 3 set flag, 4 clear flag, 5 conditional read, 6 conditional write. Results appear on the cycle after the request. An idle request gives ok 0 and read data 0. A plain read returns the stored word with ok 1 and changes nothing. A plain write stores the word, leaves the flag unchanged, and gives ok 1 with read data 0.
- R3: Set flag and clear flag give ok 1 and read data 0. The flag bit at position index of full_flags takes the new value on the cycle after the request and not before.
- R4: A conditional write to an empty mailbox stores the word, sets the flag and gives ok 1. To a full mailbox it gives ok 0 and changes neither data nor flag.
- R5: A conditional read of a full mailbox returns the word, clears the flag and gives ok 1. Of an empty mailbox it gives ok 0 and read data 0 and changes nothing.
- R6: When both sides make a non-idle request to the same index in one cycle, the core request takes effect. The peripheral gets ok 0 and read data 0, and its request has no effect.
- R7: A request whose index is above 128 gives ok 0 and read data 0 and changes no mailbox.
- R8: Requests from the two sides to different mailboxes in one cycle are both carried out.
- R9: A word written by the core is returned by a core read of the same mailbox issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_op | input | 3 | Core-side operation code |
| core_idx | input | 8 | Core-side mailbox index |
| core_wdata | input | 32 | Core-side write word |
| core_rdata | output | 32 | Core-side read word, one cycle after the request |
| core_ok | output | 1 | Core-side success, one cycle after the request |
| periph_op | input | 3 | Peripheral-side operation code |
| periph_idx | input | 8 | Peripheral-side mailbox index |
| periph_wdata | input | 32 | Peripheral-side write word |
| periph_rdata | output | 32 | Peripheral-side read word, one cycle after the request |
| periph_ok | output | 1 | Peripheral-side success, one cycle after the request |
| full_flags | output | 129 | Occupancy flag of every mailbox, bit n for index n |

## Verification
The properties assume that the operation inputs only ever carry the seven defined codes, and that the indices are known values whenever an operation is non-idle. A value of 7 is treated as idle by the design, but no property covers it. The stimulus draws every operation from the named codes and drives idle with index zero between requests. Out-of-range indices appear only in the dedicated R7 steps. Every request is applied for exactly one clock, so a property's antecedent cycle always matches the request the bench intends.

// File: rtl/fmpa_pkg.sv
// Package: shared types for the flagged mailbox port array.
// Holds the operation code encoding and the per-side action bundle.
package fmpa_pkg;

    localparam int unsigned FMPA_PORTS  = 129;
    localparam int unsigned FMPA_DATA_W = 32;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_SETF = 3'd3,
        OP_CLRF = 3'd4,
        OP_CRD  = 3'd5,
        OP_CWR  = 3'd6
    } port_op_e;

    typedef struct packed {
        logic wr_data;
        logic set_flag;
        logic clr_flag;
        logic ok;
        logic give_data;
    } side_act_t;

endpackage

// File: rtl/fmpa_arbiter.sv
// Module: fmpa_arbiter
// Decides which side's request may act this cycle. It checks each index
// against the array size and blocks a peripheral request that targets the
// same mailbox as a non-idle core request.
// Assumes: operation codes are known; code 7 counts as idle.
module fmpa_arbiter #(
    parameter int unsigned PORTS = 129,
    parameter int unsigned IDX_W = 8
) (
    input  logic [2:0]       core_op,
    input  logic [IDX_W-1:0] core_idx,
    input  logic [2:0]       periph_op,
    input  logic [IDX_W-1:0] periph_idx,
    output logic             core_grant,
    output logic             periph_grant
);
    import fmpa_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PORTS - 1);

    logic core_active;
    logic periph_active;
    logic same_target;

    // Grant logic: range check per side, with the core winning a shared index.
    always_comb begin
        core_active   = (core_op != OP_NOP) && (core_op <= OP_CWR);
        periph_active = (periph_op != OP_NOP) && (periph_op <= OP_CWR);
        same_target   = core_active && periph_active && (core_idx == periph_idx);
        core_grant    = core_active && (core_idx <= LAST_IDX);
        periph_grant  = periph_active && (periph_idx <= LAST_IDX) && !same_target;
    end

endmodule

// File: rtl/fmpa_side_decode.sv
// Module: fmpa_side_decode
// Turns one side's granted request and the addressed mailbox's current flag
// into actions: data write, flag set/clear, success and read-data return.
// Assumes: grant already covers the range check and the cross-side priority.
module fmpa_side_decode (
    input  logic                 grant,
    input  logic [2:0]           op,
    input  logic                 cur_flag,
    output fmpa_pkg::side_act_t  act
);
    import fmpa_pkg::*;

    // Action decode: conditional operations consult the current flag.
    always_comb begin
        act = '0;
        if (grant) begin
            case (port_op_e'(op))
                OP_RD: begin
                    act.ok        = 1'b1;
                    act.give_data = 1'b1;
                end
                OP_WR: begin
                    act.ok      = 1'b1;
                    act.wr_data = 1'b1;
                end
                OP_SETF: begin
                    act.ok       = 1'b1;
                    act.set_flag = 1'b1;
                end
                OP_CLRF: begin
                    act.ok       = 1'b1;
                    act.clr_flag = 1'b1;
                end
                OP_CRD: begin
                    if (cur_flag) begin
                        act.ok        = 1'b1;
                        act.give_data = 1'b1;
                        act.clr_flag  = 1'b1;
                    end
                end
                OP_CWR: begin
                    if (!cur_flag) begin
                        act.ok       = 1'b1;
                        act.wr_data  = 1'b1;
                        act.set_flag = 1'b1;
                    end
                end
                default: act = '0;
            endcase
        end
    end

endmodule

// File: rtl/fmpa_slot.sv
// Module: fmpa_slot
// One mailbox: a data word and its full/empty flag. Both sides may update it.
// The core's updates are applied first.
// Assumes: the arbiter never lets both sides act on one slot in one cycle.
module fmpa_slot #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c_sel,
    input  logic              c_wr,
    input  logic              c_set,
    input  logic              c_clr,
    input  logic [DATA_W-1:0] c_wdata,
    input  logic              p_sel,
    input  logic              p_wr,
    input  logic              p_set,
    input  logic              p_clr,
    input  logic [DATA_W-1:0] p_wdata,
    output logic [DATA_W-1:0] data_q,
    output logic              flag_q
);

    // Data register: takes the core word, else the peripheral word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (c_sel && c_wr) begin
            data_q <= c_wdata;
        end else if (p_sel && p_wr) begin
            data_q <= p_wdata;
        end
    end

    // Flag register: set or clear by the selected side, core first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (c_sel && (c_set || c_clr)) begin
            flag_q <= c_set;
        end else if (p_sel && (p_set || p_clr)) begin
            flag_q <= p_set;
        end
    end

endmodule

// File: rtl/flagged_mailbox.sv
// Module: flagged_mailbox (top)
// An array of PORTS mailboxes, each a DATA_W word with a full flag. There are
// two request ports, core and peripheral. Responses are registered and come
// one cycle after the request. The flag vector is exported straight from
// the slot registers.
// Assumes: synchronous active-low reset; requests last one cycle each.
module flagged_mailbox #(
    parameter int unsigned PORTS  = fmpa_pkg::FMPA_PORTS,
    parameter int unsigned DATA_W = fmpa_pkg::FMPA_DATA_W,
    parameter int unsigned IDX_W  = $clog2(PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        core_op,
    input  logic [IDX_W-1:0]  core_idx,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_ok,
    input  logic [2:0]        periph_op,
    input  logic [IDX_W-1:0]  periph_idx,
    input  logic [DATA_W-1:0] periph_wdata,
    output logic [DATA_W-1:0] periph_rdata,
    output logic              periph_ok,
    output logic [PORTS-1:0]  full_flags
);
    import fmpa_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PORTS - 1);

    logic              core_grant;
    logic              periph_grant;
    side_act_t         core_act;
    side_act_t         periph_act;
    logic [DATA_W-1:0] slot_data [PORTS];
    logic [PORTS-1:0]  slot_flag;
    logic              core_cur_flag;
    logic              periph_cur_flag;
    logic [DATA_W-1:0] core_cur_data;
    logic [DATA_W-1:0] periph_cur_data;

    fmpa_arbiter #(
        .PORTS (PORTS),
        .IDX_W (IDX_W)
    ) u_arb (
        .core_op      (core_op),
        .core_idx     (core_idx),
        .periph_op    (periph_op),
        .periph_idx   (periph_idx),
        .core_grant   (core_grant),
        .periph_grant (periph_grant)
    );

    // Read selection: the addressed slot's current word and flag per side.
    always_comb begin
        core_cur_flag   = 1'b0;
        core_cur_data   = '0;
        periph_cur_flag = 1'b0;
        periph_cur_data = '0;
        if (core_idx <= LAST_IDX) begin
            core_cur_flag = slot_flag[core_idx];
            core_cur_data = slot_data[core_idx];
        end
        if (periph_idx <= LAST_IDX) begin
            periph_cur_flag = slot_flag[periph_idx];
            periph_cur_data = slot_data[periph_idx];
        end
    end

    fmpa_side_decode u_core_dec (
        .grant    (core_grant),
        .op       (core_op),
        .cur_flag (core_cur_flag),
        .act      (core_act)
    );

    fmpa_side_decode u_periph_dec (
        .grant    (periph_grant),
        .op       (periph_op),
        .cur_flag (periph_cur_flag),
        .act      (periph_act)
    );

    for (genvar g = 0; g < PORTS; g++) begin : g_slot
        fmpa_slot #(
            .DATA_W (DATA_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .c_sel   (core_grant && (core_idx == IDX_W'(g))),
            .c_wr    (core_act.wr_data),
            .c_set   (core_act.set_flag),
            .c_clr   (core_act.clr_flag),
            .c_wdata (core_wdata),
            .p_sel   (periph_grant && (periph_idx == IDX_W'(g))),
            .p_wr    (periph_act.wr_data),
            .p_set   (periph_act.set_flag),
            .p_clr   (periph_act.clr_flag),
            .p_wdata (periph_wdata),
            .data_q  (slot_data[g]),
            .flag_q  (slot_flag[g])
        );
    end

    assign full_flags = slot_flag;

    // Response registers: success bit and returned word, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_ok      <= 1'b0;
            core_rdata   <= '0;
            periph_ok    <= 1'b0;
            periph_rdata <= '0;
        end else begin
            core_ok      <= core_act.ok;
            core_rdata   <= core_act.give_data ? core_cur_data : '0;
            periph_ok    <= periph_act.ok;
            periph_rdata <= periph_act.give_data ? periph_cur_data : '0;
        end
    end

endmodule

// File: rtl/fmpa_checker.sv
// Module: fmpa_checker
// Temporal properties of the mailbox array, checked at its ports only.
// Bound into every flagged_mailbox instance.
module fmpa_checker #(
    parameter int unsigned PORTS  = 129,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        core_op,
    input logic [IDX_W-1:0]  core_idx,
    input logic [2:0]        periph_op,
    input logic [IDX_W-1:0]  periph_idx,
    input logic [DATA_W-1:0] core_rdata,
    input logic              core_ok,
    input logic [DATA_W-1:0] periph_rdata,
    input logic              periph_ok,
    input logic [PORTS-1:0]  full_flags
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PORTS - 1);

    // R1: reset clears flags and responses
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (full_flags == '0 && !core_ok && !periph_ok))
        else $error("p_reset_clears_r1");

    // R2: an idle request never reports success
    p_idle_no_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_op == 3'd0) |=> (!core_ok && core_rdata == '0))
        else $error("p_idle_no_ok_r2");

    // R2: a plain read on its own leaves every flag untouched
    p_read_keeps_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_op == 3'd1 && periph_op == 3'd0) |=> (full_flags == $past(full_flags)))
        else $error("p_read_keeps_flags_r2");

    // R4: a conditional write in range leaves the mailbox full
    p_cwr_leaves_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_op == 3'd6 && core_idx <= LAST_IDX) |=> full_flags[$past(core_idx)])
        else $error("p_cwr_leaves_full_r4");

    // R5: a conditional read of an empty mailbox fails with zero data
    p_crd_empty_fails_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_op == 3'd5 && core_idx <= LAST_IDX && !full_flags[core_idx])
        |=> (!core_ok && core_rdata == '0))
        else $error("p_crd_empty_fails_r5");

    // R6: the peripheral loses a same-index collision
    p_conflict_periph_fails_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_op != 3'd0 && periph_op != 3'd0 && core_idx == periph_idx)
        |=> (!periph_ok && periph_rdata == '0))
        else $error("p_conflict_periph_fails_r6");

    // R7: an out-of-range index never succeeds
    p_range_fails_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_op != 3'd0 && core_idx > LAST_IDX) |=> !core_ok)
        else $error("p_range_fails_r7");

endmodule

bind flagged_mailbox fmpa_checker #(
    .PORTS  (PORTS),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_fmpa_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_op      (core_op),
    .core_idx     (core_idx),
    .periph_op    (periph_op),
    .periph_idx   (periph_idx),
    .core_rdata   (core_rdata),
    .core_ok      (core_ok),
    .periph_rdata (periph_rdata),
    .periph_ok    (periph_ok),
    .full_flags   (full_flags)
);

// File: tb/flagged_mailbox_test.sv
`timescale 1ns/1ps
// Bench for flagged_mailbox: a vector table walked by one loop, then
// directed tests for flag timing, back-to-back core transfer and reset.
module flagged_mailbox_test;

    localparam logic [2:0] NOP = 3'd0, RD = 3'd1, WR = 3'd2, SF = 3'd3,
                           CF = 3'd4, CR = 3'd5, CW = 3'd6;

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  cop;
        logic [7:0]  cidx;
        logic [31:0] cwd;
        logic [2:0]  pop;
        logic [7:0]  pidx;
        logic [31:0] pwd;
        logic        ecok;
        logic [31:0] ecrd;
        logic        epok;
        logic [31:0] eprd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        // R2: plain write
        '{8'd2, WR, 8'd5, 32'hA5A50001, NOP, 8'd0, 32'h0, 1'b1, 32'h0, 1'b0, 32'h0},
        // R8: core read and peripheral write on different mailboxes
        '{8'd8, RD, 8'd5, 32'h0, WR, 8'd128, 32'h12345678, 1'b1, 32'hA5A50001, 1'b1, 32'h0},
        // R5: conditional read of empty mailbox fails
        '{8'd5, CR, 8'd5, 32'h0, RD, 8'd128, 32'h0, 1'b0, 32'h0, 1'b1, 32'h12345678},
        // R4: conditional writes into empty mailboxes
        '{8'd4, CW, 8'd7, 32'h0000BEEF, CW, 8'd9, 32'h99, 1'b1, 32'h0, 1'b1, 32'h0},
        // R4: conditional write into full mailbox fails; R5 read of full succeeds
        '{8'd4, CW, 8'd7, 32'h0000DEAD, CR, 8'd9, 32'h0, 1'b0, 32'h0, 1'b1, 32'h99},
        // R5: read returns untouched word; mailbox 9 now empty
        '{8'd5, CR, 8'd7, 32'h0, CR, 8'd9, 32'h0, 1'b1, 32'h0000BEEF, 1'b0, 32'h0},
        // R3: set flag
        '{8'd3, SF, 8'd128, 32'h0, NOP, 8'd0, 32'h0, 1'b1, 32'h0, 1'b0, 32'h0},
        // R5: peripheral conditional read after core set flag
        '{8'd5, NOP, 8'd0, 32'h0, CR, 8'd128, 32'h0, 1'b0, 32'h0, 1'b1, 32'h12345678},
        // R6: collision, core wins
        '{8'd6, WR, 8'd3, 32'h333, WR, 8'd3, 32'h444, 1'b1, 32'h0, 1'b0, 32'h0},
        // R6: peripheral write had no effect
        '{8'd6, NOP, 8'd0, 32'h0, RD, 8'd3, 32'h0, 1'b0, 32'h0, 1'b1, 32'h333},
        // R7: out-of-range indices
        '{8'd7, WR, 8'd129, 32'h1, RD, 8'd200, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0},
        // R6: conditional write collision
        '{8'd6, CW, 8'd128, 32'h55, CW, 8'd128, 32'h66, 1'b1, 32'h0, 1'b0, 32'h0},
        // R6: core word survived
        '{8'd6, NOP, 8'd0, 32'h0, CR, 8'd128, 32'h0, 1'b0, 32'h0, 1'b1, 32'h55},
        // R3: set flags from both sides
        '{8'd3, SF, 8'd0, 32'h0, SF, 8'd1, 32'h0, 1'b1, 32'h0, 1'b1, 32'h0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   core_op = NOP;
    logic [7:0]   core_idx = '0;
    logic [31:0]  core_wdata = '0;
    logic [31:0]  core_rdata;
    logic         core_ok;
    logic [2:0]   periph_op = NOP;
    logic [7:0]   periph_idx = '0;
    logic [31:0]  periph_wdata = '0;
    logic [31:0]  periph_rdata;
    logic         periph_ok;
    logic [128:0] full_flags;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flagged_mailbox uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_op      (core_op),
        .core_idx     (core_idx),
        .core_wdata   (core_wdata),
        .core_rdata   (core_rdata),
        .core_ok      (core_ok),
        .periph_op    (periph_op),
        .periph_idx   (periph_idx),
        .periph_wdata (periph_wdata),
        .periph_rdata (periph_rdata),
        .periph_ok    (periph_ok),
        .full_flags   (full_flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag, input logic [128:0] exp);
        n_chk++;
        if (full_flags !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, full_flags, exp);
        end
    endtask

    task automatic drive(input logic [2:0] cop, input logic [7:0] cidx, input logic [31:0] cwd,
                         input logic [2:0] pop, input logic [7:0] pidx, input logic [31:0] pwd);
        core_op = cop; core_idx = cidx; core_wdata = cwd;
        periph_op = pop; periph_idx = pidx; periph_wdata = pwd;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state after reset
        chk_flags("R1 flags after reset", '0);
        chk("R1 core_ok after reset", {31'b0, core_ok}, 32'h0);
        chk("R1 periph_rdata after reset", periph_rdata, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].cop, VEC[i].cidx, VEC[i].cwd, VEC[i].pop, VEC[i].pidx, VEC[i].pwd);
            @(negedge clk);
            chk($sformatf("R%0d vec%0d core_ok", VEC[i].req, i), {31'b0, core_ok}, {31'b0, VEC[i].ecok});
            chk($sformatf("R%0d vec%0d core_rdata", VEC[i].req, i), core_rdata, VEC[i].ecrd);
            chk($sformatf("R%0d vec%0d periph_ok", VEC[i].req, i), {31'b0, periph_ok}, {31'b0, VEC[i].epok});
            chk($sformatf("R%0d vec%0d periph_rdata", VEC[i].req, i), periph_rdata, VEC[i].eprd);
        end
        drive(NOP, 8'd0, 32'h0, NOP, 8'd0, 32'h0);
        // R8 / R7: only mailboxes 0 and 1 remain full
        chk_flags("R8 flags after table", 129'h3);

        // R3: a clear shows only after the edge
        @(negedge clk);
        drive(CF, 8'd0, 32'h0, NOP, 8'd0, 32'h0);
        #1;
        chk_flags("R3 flag before edge", 129'h3);
        @(negedge clk);
        chk_flags("R3 flag after edge", 129'h2);

        // R9: core write then core read in the next cycle
        drive(WR, 8'd40, 32'hCAFE0040, NOP, 8'd0, 32'h0);
        @(negedge clk);
        drive(RD, 8'd40, 32'h0, NOP, 8'd0, 32'h0);
        @(negedge clk);
        chk("R9 back-to-back read", core_rdata, 32'hCAFE0040);
        chk("R9 back-to-back ok", {31'b0, core_ok}, 32'h1);

        // R1: reset mid-run clears data and flags
        drive(WR, 8'd41, 32'h1, SF, 8'd42, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_flags("R1 flags after mid-run reset", '0);
        chk("R1 core_ok during reset", {31'b0, core_ok}, 32'h0);
        rst_n = 1'b1;
        drive(RD, 8'd40, 32'h0, RD, 8'd5, 32'h0);
        @(negedge clk);
        chk("R1 data cleared core", core_rdata, 32'h0);
        chk("R1 data cleared periph", periph_rdata, 32'h0);
        drive(NOP, 8'd0, 32'h0, NOP, 8'd0, 32'h0);
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule